// File: doc/BRIEF.md
# Stack frame save/restore sequencer

This block carries out the compressed-encoding SAVE and RESTORE stack-frame instructions. It turns each one into a series of single-word memory accesses. When `start` is pulsed it decodes the instruction halfword, plus an optional prefix halfword, and works out the frame size. It then walks a fixed list of register slots. For every enabled slot it issues one store (SAVE) or one load (RESTORE) through a valid/ready memory port, reading the register file for stores and writing it for loads. The last step updates the stack pointer, register 29.

Three fields choose which registers take part:
- a 3-bit mask selecting the return address and the two callee-saved registers 16 and 17;
- a 3-bit count of extra saved registers;
- a 4-bit argument field that two tables turn into an incoming-argument count and a static-argument count.

The argument field is only present in the prefixed form. An encoding the block cannot run raises a one-cycle error flag and nothing else happens.

Top module: `stack_frame_seq`

## Requirements
- R1: `start` is accepted only when `instrWord[15:8]` is 8'b01100100. When `extended` is 1, `prefixWord[15:11]` must also be 5'b11110 and the argument field `prefixWord[3:0]` must differ from 15. Any other start gives a one-cycle `illegal` pulse on the next cycle, with no memory access and no register write.
- R2: Frame size in bytes:
  - short form (`extended`=0): 128 when `instrWord[3:0]` is 0, otherwise `instrWord[3:0]`×8;
  - prefixed form: {`prefixWord[7:4]`,`instrWord[3:0]`}×8.
- R3: On SAVE (`instrWord[7]`=1), the argument field gives the incoming count: 0 for values 0–3 and 11, 1 for 4–7, 2 for 8–10, 3 for 12–13, 4 for 14. That many registers starting at 4 and ascending are stored first, to base+0, base+4, base+8 and base+12, where base is the old SP. The short form uses an argument field of 0.
- R4: The remaining accesses go to base−4, base−8 and so on, one word lower each time, in this order:
  - register 31 if `instrWord[6]` is set;
  - for an extra count k = `prefixWord[10:8]` (0 in short form), the last k entries of the list 30, 23, 22, 21, 20, 19, 18;
  - register 17 if `instrWord[4]` is set;
  - register 16 if `instrWord[5]` is set.
- R5: The argument field also gives a static count: 4 for value 11, 0 for value 14, and the value modulo 4 otherwise. That many registers, starting at 7 and descending, continue the downward sequence after R4.
- R6: SAVE stores the low 32 bits of each register and then writes old SP − frame size into register 29.
- R7: RESTORE uses SP + frame size as base. It loads every R4/R5 slot but none of the R3 slots. Each loaded word is written to its register sign-extended to XLEN, and register 29 then receives the base.
- R8: At most one memory request is outstanding. `memValid`, `memAddr`, `memWdata` and `memWrite` stay unchanged until `memReady` is sampled high, and `memValid` is low while idle.
- R9: `busy` is high from the cycle after an accepted start until the SP write. `done` is a single-cycle pulse in the cycle after the SP write.
- R10: `start` is ignored while `busy` is high; the running operation completes unchanged.
- R11: Synchronous active-high `rst` returns the block to idle at once, with `busy`, `done`, `illegal` and `memValid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin decoding the presented instruction |
| extended | input | 1 | Prefix halfword is valid |
| prefixWord | input | 16 | Prefix halfword |
| instrWord | input | 16 | Instruction halfword |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle unrunnable-encoding pulse |
| rfRdAddr | output | 5 | Register file read index |
| rfRdData | input | XLEN | Register file read data (combinational) |
| rfWrEn | output | 1 | Register file write enable |
| rfWrAddr | output | 5 | Register file write index |
| rfWrData | output | XLEN | Register file write data |
| memValid | output | 1 | Memory request valid |
| memWrite | output | 1 | Request is a store |
| memAddr | output | XLEN | Byte address of the word |
| memWdata | output | 32 | Store data |
| memReady | input | 1 | Memory accepts/completes the request |
| memRdata | input | 32 | Load data, valid with memReady |

## Verification
Several patterns are tried, each checked access by access:
- **Directed corners.** A short-form SAVE with only the return address and a zero frame field exposes the 128-byte default. Full-mask prefixed SAVE and RESTORE with argument values 14 and 11 push the incoming and static tables to their extremes and reach the largest frame.
- **Random operations.** Random prefixed and short operations under random `memReady` stalls separate correct slot ordering and address stepping from off-by-one skips, and show that requests hold steady while stalled.
- **Loads.** Restores from random memory words, half of them negative, tell sign extension apart from zero extension, and show that incoming-argument registers are left alone.
- **Control corners.** An argument value of 15, a bad opcode, a start pulsed in mid-run and a reset in mid-run check the rejection and idle paths.

// File: rtl/svr_pkg.sv
package svr_pkg;

  localparam int SLOT_N  = 18;              // fixed walk: 4 incoming, ra, 7 extra, s1, s0, 4 static
  localparam int SLOT_W  = $clog2(SLOT_N);
  localparam int FRAME_W = 11;              // 255*8 = 2040 is the largest frame
  localparam int SP_IDX  = 29;

  typedef struct packed {
    logic       loadBase;  // latch SP-derived base, pointer and final SP
    logic       capture;   // latch address and store data for one slot
    logic       upward;    // slot addresses above the base
    logic [1:0] argIdx;    // word offset for upward slots
    logic       spWrite;   // select final SP as write data
  } dpStrobe_t;

  function automatic logic [2:0] incomingCount(input logic [3:0] f);
    case (f)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd11: incomingCount = 3'd0;
      4'd4, 4'd5, 4'd6, 4'd7:        incomingCount = 3'd1;
      4'd8, 4'd9, 4'd10:             incomingCount = 3'd2;
      4'd12, 4'd13:                  incomingCount = 3'd3;
      4'd14:                         incomingCount = 3'd4;
      default:                       incomingCount = 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] staticCount(input logic [3:0] f);
    case (f)
      4'd1, 4'd5, 4'd9, 4'd13: staticCount = 3'd1;
      4'd2, 4'd6, 4'd10:       staticCount = 3'd2;
      4'd3, 4'd7:              staticCount = 3'd3;
      4'd11:                   staticCount = 3'd4;
      default:                 staticCount = 3'd0;
    endcase
  endfunction

  function automatic logic [4:0] slotReg(input logic [SLOT_W-1:0] s);
    case (s)
      5'd0:  slotReg = 5'd4;
      5'd1:  slotReg = 5'd5;
      5'd2:  slotReg = 5'd6;
      5'd3:  slotReg = 5'd7;
      5'd4:  slotReg = 5'd31;
      5'd5:  slotReg = 5'd30;
      5'd6:  slotReg = 5'd23;
      5'd7:  slotReg = 5'd22;
      5'd8:  slotReg = 5'd21;
      5'd9:  slotReg = 5'd20;
      5'd10: slotReg = 5'd19;
      5'd11: slotReg = 5'd18;
      5'd12: slotReg = 5'd17;
      5'd13: slotReg = 5'd16;
      5'd14: slotReg = 5'd7;
      5'd15: slotReg = 5'd6;
      5'd16: slotReg = 5'd5;
      5'd17: slotReg = 5'd4;
      default: slotReg = 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/svr_decode.sv
module svr_decode
  import svr_pkg::*;
(
  input  logic               extended,
  input  logic [15:0]        prefixWord,
  input  logic [15:0]        instrWord,
  output logic               legal,
  output logic               isSave,
  output logic [2:0]         mask,
  output logic [2:0]         xCnt,
  output logic [2:0]         nIn,
  output logic [2:0]         nStatic,
  output logic [FRAME_W-1:0] frameBytes
);

  logic [3:0] argField;
  logic       opOk;
  logic       preOk;

  always_comb begin
    argField = extended ? prefixWord[3:0] : 4'd0;
    opOk     = instrWord[15:8] == 8'b0110_0100;
    preOk    = !extended || ((prefixWord[15:11] == 5'b11110) && (prefixWord[3:0] != 4'd15));
    legal    = opOk && preOk;
    isSave   = instrWord[7];
    mask     = instrWord[6:4];
    xCnt     = extended ? prefixWord[10:8] : 3'd0;
    nIn      = incomingCount(argField);
    nStatic  = staticCount(argField);
    if (extended)
      frameBytes = {prefixWord[7:4], instrWord[3:0], 3'b000};
    else if (instrWord[3:0] == 4'd0)
      frameBytes = FRAME_W'(128);
    else
      frameBytes = FRAME_W'({instrWord[3:0], 3'b000});
  end

endmodule

// File: rtl/svr_ctrl.sv
module svr_ctrl
  import svr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       decLegal,
  input  logic       decSave,
  input  logic [2:0] decMask,
  input  logic [2:0] decXCnt,
  input  logic [2:0] decNIn,
  input  logic [2:0] decNStatic,
  input  logic       memReady,
  output logic       busy,
  output logic       done,
  output logic       illegal,
  output logic       memValid,
  output logic       memWrite,
  output logic [4:0] rfRdAddr,
  output logic       rfWrEn,
  output logic [4:0] rfWrAddr,
  output dpStrobe_t  strobe
);

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_REQ, S_FIN} state_t;

  state_t            state;
  logic [SLOT_W-1:0] slot;
  logic              saveOp;
  logic [2:0]        mask, xCnt, nIn, nStatic;
  logic [4:0]        curReg;
  logic              doneQ, illQ;
  logic              slotOn, lastSlot, accept;

  always_comb begin
    lastSlot = slot == SLOT_W'(SLOT_N - 1);
    if (slot < 5'd4)        slotOn = saveOp && (slot < {2'b00, nIn});
    else if (slot == 5'd4)  slotOn = mask[2];
    else if (slot <= 5'd11) slotOn = ((slot - 5'd5) + {2'b00, xCnt}) >= 5'd7;
    else if (slot == 5'd12) slotOn = mask[0];
    else if (slot == 5'd13) slotOn = mask[1];
    else                    slotOn = (slot - 5'd14) < {2'b00, nStatic};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      slot    <= '0;
      saveOp  <= 1'b0;
      mask    <= '0;
      xCnt    <= '0;
      nIn     <= '0;
      nStatic <= '0;
      curReg  <= '0;
      doneQ   <= 1'b0;
      illQ    <= 1'b0;
    end else begin
      doneQ <= state == S_FIN;
      illQ  <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (decLegal) begin
            state   <= S_SCAN;
            slot    <= '0;
            saveOp  <= decSave;
            mask    <= decMask;
            xCnt    <= decXCnt;
            nIn     <= decNIn;
            nStatic <= decNStatic;
          end else begin
            illQ <= 1'b1;
          end
        end
        S_SCAN: begin
          if (slotOn) begin
            curReg <= slotReg(slot);
            state  <= S_REQ;
          end else if (lastSlot) begin
            state <= S_FIN;
          end else begin
            slot <= slot + 1'b1;
          end
        end
        S_REQ: if (memReady) begin
          if (lastSlot) begin
            state <= S_FIN;
          end else begin
            slot  <= slot + 1'b1;
            state <= S_SCAN;
          end
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    accept          = (state == S_IDLE) && start && decLegal;
    busy            = state != S_IDLE;
    done            = doneQ;
    illegal         = illQ;
    memValid        = state == S_REQ;
    memWrite        = saveOp;
    rfRdAddr        = (state == S_IDLE) ? 5'(SP_IDX) : slotReg(slot);
    rfWrEn          = ((state == S_REQ) && memReady && !saveOp) || (state == S_FIN);
    rfWrAddr        = (state == S_FIN) ? 5'(SP_IDX) : curReg;
    strobe.loadBase = accept;
    strobe.capture  = (state == S_SCAN) && slotOn;
    strobe.upward   = slot < 5'd4;
    strobe.argIdx   = slot[1:0];
    strobe.spWrite  = state == S_FIN;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !busy |-> !memValid && !rfWrEn); // R8
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst) illegal |-> !busy && !done); // R1
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    ((state == S_SCAN) || (state == S_REQ)) && start |=> busy); // R10

endmodule

// File: rtl/svr_datapath.sv
module svr_datapath
  import svr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  dpStrobe_t          strobe,
  input  logic               startSave,
  input  logic [FRAME_W-1:0] frameBytes,
  input  logic [XLEN-1:0]    rfRdData,
  input  logic [31:0]        memRdata,
  output logic [XLEN-1:0]    memAddr,
  output logic [31:0]        memWdata,
  output logic [XLEN-1:0]    rfWrData
);

  logic [XLEN-1:0] baseQ, ptrQ, finalQ, addrQ;
  logic [31:0]     wdataQ;
  logic [XLEN-1:0] frameExt, baseNext;

  always_comb begin
    frameExt = XLEN'(frameBytes);
    baseNext = startSave ? rfRdData : rfRdData + frameExt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      baseQ  <= '0;
      ptrQ   <= '0;
      finalQ <= '0;
      addrQ  <= '0;
      wdataQ <= '0;
    end else begin
      if (strobe.loadBase) begin
        baseQ  <= baseNext;
        ptrQ   <= baseNext;
        finalQ <= startSave ? rfRdData - frameExt : baseNext;
      end
      if (strobe.capture) begin
        wdataQ <= rfRdData[31:0];
        if (strobe.upward) begin
          addrQ <= baseQ + XLEN'({strobe.argIdx, 2'b00});
        end else begin
          addrQ <= ptrQ - XLEN'(4);
          ptrQ  <= ptrQ - XLEN'(4);
        end
      end
    end
  end

  always_comb begin
    memAddr  = addrQ;
    memWdata = wdataQ;
    rfWrData = strobe.spWrite ? finalQ : XLEN'($signed(memRdata));
  end

  AST_PTR_BELOW_BASE: assert property (@(posedge clk) disable iff (rst)
    strobe.capture && !strobe.upward |=> memAddr != baseQ); // R4

endmodule

// File: rtl/stack_frame_seq.sv
module stack_frame_seq
  import svr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            extended,
  input  logic [15:0]     prefixWord,
  input  logic [15:0]     instrWord,
  output logic            busy,
  output logic            done,
  output logic            illegal,
  output logic [4:0]      rfRdAddr,
  input  logic [XLEN-1:0] rfRdData,
  output logic            rfWrEn,
  output logic [4:0]      rfWrAddr,
  output logic [XLEN-1:0] rfWrData,
  output logic            memValid,
  output logic            memWrite,
  output logic [XLEN-1:0] memAddr,
  output logic [31:0]     memWdata,
  input  logic            memReady,
  input  logic [31:0]     memRdata
);

  logic               decLegal, decSave;
  logic [2:0]         decMask, decXCnt, decNIn, decNStatic;
  logic [FRAME_W-1:0] frameBytes;
  dpStrobe_t          strobe;

  svr_decode dec_i (
    .extended(extended), .prefixWord(prefixWord), .instrWord(instrWord),
    .legal(decLegal), .isSave(decSave), .mask(decMask), .xCnt(decXCnt),
    .nIn(decNIn), .nStatic(decNStatic), .frameBytes(frameBytes)
  );

  svr_ctrl ctrl_i (
    .clk(clk), .rst(rst), .start(start),
    .decLegal(decLegal), .decSave(decSave), .decMask(decMask), .decXCnt(decXCnt),
    .decNIn(decNIn), .decNStatic(decNStatic), .memReady(memReady),
    .busy(busy), .done(done), .illegal(illegal), .memValid(memValid), .memWrite(memWrite),
    .rfRdAddr(rfRdAddr), .rfWrEn(rfWrEn), .rfWrAddr(rfWrAddr), .strobe(strobe)
  );

  svr_datapath #(.XLEN(XLEN)) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .startSave(decSave), .frameBytes(frameBytes),
    .rfRdData(rfRdData), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .rfWrData(rfWrData)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    memValid && !memReady |=> memValid && $stable(memAddr) && $stable(memWdata) && $stable(memWrite)); // R8
  AST_LOAD_NOT_SP: assert property (@(posedge clk) disable iff (rst)
    rfWrEn && memValid |-> !memWrite && (rfWrAddr != 5'(SP_IDX))); // R7

endmodule

// File: tb/stack_frame_seq_tb_top.sv
`timescale 1ns/1ps
module stack_frame_seq_tb_top;

  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic            extended = 1'b0;
  logic [15:0]     prefixWord = '0;
  logic [15:0]     instrWord = '0;
  logic            busy, done, illegal;
  logic [4:0]      rfRdAddr, rfWrAddr;
  logic [XLEN-1:0] rfRdData, rfWrData, memAddr;
  logic            rfWrEn, memValid, memWrite;
  logic [31:0]     memWdata, memRdata;
  logic            memReady = 1'b0;

  logic [63:0] rf [32];
  logic [63:0] rf0 [32];
  logic [63:0] expRf [32];
  logic [31:0] mem [2048];

  logic [63:0] expAddr [32];
  int          expReg [32];
  string       expTag [32];
  int          expCnt;
  logic [63:0] obsAddr [32];
  logic        obsWrite [32];
  logic [31:0] obsData [32];
  int          obsCnt, doneCnt, illCnt, holdErr, cycles;
  int          checks = 0, fails = 0;
  bit          prevStall = 0, wdFired = 0;
  logic [63:0] pAddr;
  logic [31:0] pData;
  logic        pWrite;

  always #2.5 clk = ~clk;

  stack_frame_seq #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst(rst), .start(start), .extended(extended),
    .prefixWord(prefixWord), .instrWord(instrWord),
    .busy(busy), .done(done), .illegal(illegal),
    .rfRdAddr(rfRdAddr), .rfRdData(rfRdData), .rfWrEn(rfWrEn),
    .rfWrAddr(rfWrAddr), .rfWrData(rfWrData),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memReady(memReady), .memRdata(memRdata)
  );

  assign rfRdData = rf[rfRdAddr];
  assign memRdata = mem[memAddr[12:2]];

  always @(negedge clk) memReady <= ($urandom % 4) != 0;

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // memory, register file and observation model
  always @(posedge clk) begin
    cycles++;
    if (rfWrEn) rf[rfWrAddr] = rfWrData;
    if (prevStall && (!memValid || memAddr != pAddr || memWdata != pData || memWrite != pWrite))
      holdErr++;
    prevStall = memValid && !memReady;
    pAddr = memAddr; pData = memWdata; pWrite = memWrite;
    if (memValid && memReady) begin
      if (memWrite) mem[memAddr[12:2]] = memWdata;
      if (obsCnt < 32) begin
        obsAddr[obsCnt] = memAddr; obsWrite[obsCnt] = memWrite; obsData[obsCnt] = memWdata;
      end
      obsCnt++;
    end
    if (done) doneCnt++;
    if (illegal) illCnt++;
    if (cycles > 150000 && !wdFired) begin
      wdFired = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int refIncoming(input int a);
    if (a <= 3 || a == 11) return 0;
    if (a <= 7) return 1;
    if (a <= 10) return 2;
    if (a <= 13) return 3;
    return 4;
  endfunction

  function automatic int refStatic(input int a);
    if (a == 11) return 4;
    if (a == 14) return 0;
    return a % 4;
  endfunction

  function automatic int refFrame(input bit ext, input logic [3:0] hi, input logic [3:0] lo);
    if (ext) return int'({hi, lo}) * 8;
    if (lo == 0) return 128;
    return int'(lo) * 8;
  endfunction

  task automatic push(input logic [63:0] a, input int r, input string t);
    expAddr[expCnt] = a; expReg[expCnt] = r; expTag[expCnt] = t; expCnt++;
  endtask

  task automatic prepare();
    for (int r = 0; r < 32; r++) rf[r] = {$urandom, $urandom};
    rf[29] = {$urandom, 32'h0000_0C00};
    for (int i = 0; i < 2048; i++) mem[i] = $urandom;
    for (int r = 0; r < 32; r++) rf0[r] = rf[r];
    obsCnt = 0; doneCnt = 0; illCnt = 0; holdErr = 0;
  endtask

  task automatic runOp(input bit ext, input bit sv, input logic [2:0] msk, input logic [2:0] xc,
                       input logic [3:0] hi, input logic [3:0] lo, input logic [3:0] ar, input bit poke);
    int a, frame, n;
    logic [63:0] sp, base, p;
    int xl [7];
    bit ok;
    xl = '{30, 23, 22, 21, 20, 19, 18};
    prepare();
    a = ext ? int'(ar) : 0;
    frame = refFrame(ext, hi, lo);
    sp = rf0[29];
    base = sv ? sp : sp + 64'(frame);
    p = base;
    expCnt = 0;
    if (sv) for (int i = 0; i < refIncoming(a); i++) push(base + 64'(4 * i), 4 + i, "R3");
    if (msk[2]) begin p -= 4; push(p, 31, "R4"); end
    for (int j = 7 - int'(ext ? xc : 3'd0); j < 7; j++) begin p -= 4; push(p, xl[j], "R4"); end
    if (msk[0]) begin p -= 4; push(p, 17, "R4"); end
    if (msk[1]) begin p -= 4; push(p, 16, "R4"); end
    for (int i = 0; i < refStatic(a); i++) begin p -= 4; push(p, 7 - i, "R5"); end
    for (int r = 0; r < 32; r++) expRf[r] = rf0[r];
    if (!sv) for (int e = 0; e < expCnt; e++) begin
      logic [31:0] w;
      w = mem[expAddr[e][12:2]];
      expRf[expReg[e]] = {{32{w[31]}}, w};
    end
    expRf[29] = sv ? sp - 64'(frame) : base;

    @(negedge clk);
    extended = ext;
    prefixWord = ext ? {5'b11110, xc, hi, ar} : 16'h0;
    instrWord = {8'b0110_0100, sv, msk, lo};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      extended = 1'b0;
      instrWord = {8'b0110_0100, ~sv, 3'b111, 4'h1};
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (doneCnt == 0 && n < 3000) begin @(negedge clk); n++; end
    @(negedge clk);

    chk(obsCnt == expCnt, "R4", "access count", 64'(obsCnt), 64'(expCnt));
    for (int e = 0; e < expCnt && e < obsCnt; e++) begin
      ok = obsAddr[e] == expAddr[e] && obsWrite[e] == sv &&
           (!sv || obsData[e] == rf0[expReg[e]][31:0]);
      chk(ok, expTag[e], $sformatf("access %0d reg %0d addr", e, expReg[e]), obsAddr[e], expAddr[e]);
    end
    chk(rf[29] == expRf[29], sv ? "R2/R6" : "R2/R7", "final SP", rf[29], expRf[29]);
    ok = 1;
    n = 0;
    for (int r = 0; r < 32; r++) if (rf[r] != expRf[r] && ok) begin ok = 0; n = r; end
    chk(ok, sv ? "R6" : "R7", $sformatf("register file r%0d", n), rf[n], expRf[n]);
    chk(doneCnt == 1 && !busy, "R9", "done pulses", 64'(doneCnt), 64'd1);
    chk(holdErr == 0, "R8", "request held while stalled", 64'(holdErr), 64'd0);
    if (poke) chk(obsCnt == expCnt && ok, "R10", "start while busy ignored", 64'(obsCnt), 64'(expCnt));
  endtask

  task automatic illegalOp(input bit ext, input logic [15:0] pre, input logic [15:0] ins, input string what);
    bit ok;
    prepare();
    @(negedge clk);
    extended = ext; prefixWord = pre; instrWord = ins; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (25) @(negedge clk);
    ok = 1;
    for (int r = 0; r < 32; r++) if (rf[r] != rf0[r]) ok = 0;
    chk(illCnt == 1 && obsCnt == 0 && !busy && doneCnt == 0 && ok, "R1", what,
        64'(illCnt), 64'd1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int r = 0; r < 32; r++) rf[r] = '0;
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    obsCnt = 0; doneCnt = 0; illCnt = 0; holdErr = 0; cycles = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !illegal && !memValid, "R11", "reset state",
        {60'd0, busy, done, illegal, memValid}, 64'd0);
    rst = 1'b0;

    // directed corners
    runOp(0, 1, 3'b100, 3'd0, 4'd0, 4'd0, 4'd0, 0);     // 128-byte default frame, ra only
    runOp(0, 0, 3'b111, 3'd0, 4'd0, 4'd15, 4'd0, 0);    // short restore, all mask bits
    runOp(1, 1, 3'b111, 3'd7, 4'd15, 4'd15, 4'd14, 0);  // four incoming, largest frame
    runOp(1, 0, 3'b111, 3'd7, 4'd15, 4'd15, 4'd11, 0);  // four static on restore
    runOp(1, 1, 3'b011, 3'd3, 4'd2, 4'd5, 4'd11, 0);    // four static on save
    runOp(1, 0, 3'b000, 3'd0, 4'd0, 4'd1, 4'd14, 0);    // restore skips incoming entirely
    runOp(1, 1, 3'b101, 3'd2, 4'd1, 4'd0, 4'd13, 1);    // start pulsed mid-run
    illegalOp(1, {5'b11110, 3'd2, 4'd1, 4'd15}, {8'b0110_0100, 1'b1, 3'b111, 4'd2}, "argument field 15");
    illegalOp(0, 16'h0, {8'b0110_0101, 1'b1, 3'b111, 4'd2}, "wrong opcode");
    illegalOp(1, {5'b11100, 3'd2, 4'd1, 4'd3}, {8'b0110_0100, 1'b0, 3'b111, 4'd2}, "wrong prefix");

    // reset while running
    prepare();
    @(negedge clk);
    extended = 1'b1; prefixWord = {5'b11110, 3'd7, 4'd3, 4'd14};
    instrWord = {8'b0110_0100, 1'b1, 3'b111, 4'd4}; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (6) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !illegal && !memValid, "R11", "reset mid-run",
        {60'd0, busy, done, illegal, memValid}, 64'd0);
    rst = 1'b0;
    doneCnt = 0;
    repeat (30) @(negedge clk);
    chk(doneCnt == 0 && !busy, "R11", "stays idle after reset", 64'(doneCnt), 64'd0);

    // random operations
    for (int k = 0; k < 40; k++) begin
      logic [3:0] ar;
      ar = 4'($urandom % 15);
      runOp(1'($urandom), 1'($urandom), 3'($urandom), 3'($urandom), 4'($urandom),
            4'($urandom), ar, (k % 8) == 3);
    end

    summary();
    $finish;
  end

endmodule